// File: doc/BRIEF.md
# Block-and-page address translator

This block maps a 32-bit effective address to a physical address for one access stream. Two translation structures are searched side by side on every request. The first is a small, fully associative array of variable-size block mappings. The second is a two-way set-associative buffer of 4 KB page mappings. A block match always takes precedence over a page match. The outcome is registered and appears one clock after the request as one of four results: hit, miss, protection fault, or nothing.

Software-style write ports load the block entries and refill page entries one at a time. A single-cycle flush input drops every page mapping. On a miss the block only reports the miss. Walking page tables, segment handling and cache access belong to neighbouring logic.

The result register is a four-state machine:
- `XS_IDLE`: no request was sampled.
- `XS_HIT`: a usable translation was found.
- `XS_MISS`: neither structure matched.
- `XS_FAULT`: the winning translation forbids the access.

On every clock edge the next state is chosen only from the current request. It does not depend on the present state:
- no request goes to `XS_IDLE`;
- a match that permits the access goes to `XS_HIT`;
- a match that is read-only on a write goes to `XS_FAULT`;
- no match goes to `XS_MISS`.

Any state can therefore follow any other.

Top module: `addr_xlate`

## Requirements
- R1: After reset all three result flags are low, and every block and page entry is invalid, so a first request reports a miss.
- R2: Each result (`hit_o`, `miss_o`, `fault_o`, `src_blk_o`, `pa_o`) reflects the request sampled at the previous rising edge. It is the `XS_IDLE` state, with all flags low, when no request was sampled.
- R3: A block entry matches when both of these hold:
  - Effective-address bits [31:17] equal its base, ignoring bits freed by its length mask.
  - Its supervisor-valid bit (`super_i`=1) or its user-valid bit (`super_i`=0) is set.

  On a block hit `src_blk_o`=1 and `pa_o` = {translated bits [31:17], `ea_i`[16:0]}.
- R4: Length mask bit k (k=0..10) covers effective-address bit 17+k. A set bit excludes that bit from the compare and copies it from the effective address into the physical address. A clear bit takes it from the physical base. A mask of 0 gives 128 KB and 11'h7FF gives 256 MB.
- R5: A user-mode request does not match a block entry whose user-valid bit is clear, even when the address matches.
- R6: A page entry is found at set `ea_i`[16:12] by comparing tag `ea_i`[31:17]. On a page hit `src_blk_o`=0 and `pa_o` = {page frame[19:0], `ea_i`[11:0]}. A refill uses `pg_vpn_i` = effective-address bits [31:12].
- R7: When the block array and the page buffer both match, the block translation is reported.
- R8: When several block entries match, the one with the lowest index is used.
- R9: A write request (`write_i`=1) whose winning translation is read-only reports `fault_o` and no hit. A read of the same entry hits. A read-only block entry faults a write even when a writable page also matches.
- R10: A request that matches neither structure reports `miss_o` and no hit.
- R11: Each set keeps a one-bit pointer to its victim way, which is 0 after reset.
  - A refill writes the victim way and then points the pointer at the other way.
  - A page hit during a request points the pointer away from the way that hit.
- R12: A pulse on `inval_all_i` invalidates every page entry in one cycle, so a request in the next cycle cannot hit a page. Block entries are kept.
- R13: A pulse on `blk_we_i` loads entry `blk_idx_i` with the base, mask, physical base, valid bits and read-only bit presented, replacing its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request strobe |
| ea_i | input | 32 | Effective address |
| super_i | input | 1 | 1 = supervisor access, 0 = user access |
| write_i | input | 1 | 1 = write access, 0 = read access |
| inval_all_i | input | 1 | Invalidate all page entries |
| blk_we_i | input | 1 | Block entry write strobe |
| blk_idx_i | input | 2 | Block entry index to write |
| blk_base_i | input | 15 | Block effective base, address bits [31:17] |
| blk_mask_i | input | 11 | Block length mask, bit k covers address bit 17+k |
| blk_phys_i | input | 15 | Block physical base, address bits [31:17] |
| blk_sv_i | input | 1 | Block valid for supervisor accesses |
| blk_uv_i | input | 1 | Block valid for user accesses |
| blk_ro_i | input | 1 | Block is read-only |
| pg_we_i | input | 1 | Page refill strobe |
| pg_vpn_i | input | 20 | Refill virtual page number (address bits [31:12]) |
| pg_ppn_i | input | 20 | Refill physical page frame |
| pg_ro_i | input | 1 | Refill entry is read-only |
| pa_o | output | 32 | Physical address, valid with hit_o, else zero |
| hit_o | output | 1 | Translation found |
| src_blk_o | output | 1 | 1 = result from the block array, 0 = from the page buffer |
| miss_o | output | 1 | No translation found |
| fault_o | output | 1 | Access forbidden by the winning translation |

## Verification
Every lookup result is due exactly one clock after the request is sampled, with one register between request and flags. The bench drives inputs on falling edges and records each request in a scoreboard queue. It pops and compares the queue at the next falling edge, after the rising edge that loaded the result. Refills and block writes take effect at the rising edge that samples them. Invalidation also takes effect at the edge that samples it. A lookup is therefore issued only on a later cycle, so no check depends on a same-edge race. Idle results are checked at the falling edge after a cycle with no request.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int AW      = 32;
    localparam int PG_LSB  = 12;
    localparam int BLK_LSB = 17;
    localparam int MW      = 11;
    localparam int BW      = AW - BLK_LSB;
    localparam int PW      = AW - PG_LSB;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_HIT   = 2'd1,
        XS_MISS  = 2'd2,
        XS_FAULT = 2'd3
    } xl_state_e;

    typedef struct packed {
        logic [BW-1:0] base;
        logic [MW-1:0] mask;
        logic [BW-1:0] phys;
        logic          sv;
        logic          uv;
        logic          ro;
    } blk_entry_t;
endpackage

// File: rtl/xl_blk_array.sv
module xl_blk_array
    import xlate_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  blk_entry_t    wentry_i,
    input  logic [AW-1:0] ea_i,
    input  logic          super_i,
    output logic          hit_o,
    output logic          ro_o,
    output logic [AW-1:0] pa_o
);
    blk_entry_t    ent_q [N];
    logic [N-1:0]  match;
    logic [AW-1:0] cand_pa [N];
    logic [IW-1:0] sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
        end else if (we_i) begin
            ent_q[widx_i] <= wentry_i;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [BW-1:0] emask;
        logic          priv_ok;
        assign emask      = {{(BW-MW){1'b0}}, ent_q[g].mask};
        assign priv_ok    = super_i ? ent_q[g].sv : ent_q[g].uv;
        assign match[g]   = ((((ea_i[AW-1:BLK_LSB] ^ ent_q[g].base) & ~emask) == '0)
                             && priv_ok);
        assign cand_pa[g] = {(ent_q[g].phys & ~emask) | (ea_i[AW-1:BLK_LSB] & emask),
                             ea_i[BLK_LSB-1:0]};
    end

    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) sel = i[IW-1:0];
        end
    end

    assign hit_o = |match;
    assign pa_o  = cand_pa[sel];
    assign ro_o  = ent_q[sel].ro;

    // R13
    blk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ent_q[$past(widx_i)] == $past(wentry_i));
endmodule

// File: rtl/xl_page_buf.sv
module xl_page_buf
    import xlate_pkg::*;
#(
    parameter int SETS = 32,
    localparam int SW  = $clog2(SETS),
    localparam int TW  = AW - PG_LSB - SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lookup_i,
    input  logic [AW-1:0] ea_i,
    input  logic          inval_i,
    input  logic          fill_we_i,
    input  logic [PW-1:0] fill_vpn_i,
    input  logic [PW-1:0] fill_ppn_i,
    input  logic          fill_ro_i,
    output logic          hit_o,
    output logic          ro_o,
    output logic [AW-1:0] pa_o
);
    localparam int WAYS = 2;

    logic [SETS-1:0] vld_q [WAYS];
    logic [TW-1:0]   tag_q [WAYS][SETS];
    logic [PW-1:0]   ppn_q [WAYS][SETS];
    logic [SETS-1:0] ro_q  [WAYS];
    logic [SETS-1:0] lru_q;

    logic [SW-1:0]   lk_set;
    logic [TW-1:0]   lk_tag;
    logic [WAYS-1:0] way_hit;
    logic            hit_way;
    logic [SW-1:0]   f_set;
    logic [TW-1:0]   f_tag;
    logic            f_way;

    assign lk_set = ea_i[PG_LSB +: SW];
    assign lk_tag = ea_i[AW-1 -: TW];
    assign f_set  = fill_vpn_i[SW-1:0];
    assign f_tag  = fill_vpn_i[PW-1 -: TW];
    assign f_way  = lru_q[f_set];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_hit[w] = vld_q[w][lk_set] && (tag_q[w][lk_set] == lk_tag);
    end

    assign hit_way = !way_hit[0];
    assign hit_o   = |way_hit;
    assign ro_o    = ro_q[hit_way][lk_set];
    assign pa_o    = {ppn_q[hit_way][lk_set], ea_i[PG_LSB-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                vld_q[w] <= '0;
                ro_q[w]  <= '0;
            end
            lru_q <= '0;
        end else begin
            if (lookup_i && hit_o) lru_q[lk_set] <= !hit_way;
            if (inval_i) begin
                for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
            end else if (fill_we_i) begin
                vld_q[f_way][f_set] <= 1'b1;
                ro_q[f_way][f_set]  <= fill_ro_i;
                lru_q[f_set]        <= !f_way;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we_i && !inval_i) begin
            tag_q[f_way][f_set] <= f_tag;
            ppn_q[f_way][f_set] <= fill_ppn_i;
        end
    end

    // R12
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval_i |=> !hit_o);

    // R11
    victim_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we_i && !inval_i) |=> lru_q[$past(f_set)] != $past(lru_q[f_set]));
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
    import xlate_pkg::*;
#(
    parameter int BLK_N   = 4,
    parameter int PG_SETS = 32,
    localparam int IW     = (BLK_N > 1) ? $clog2(BLK_N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] ea_i,
    input  logic          super_i,
    input  logic          write_i,
    input  logic          inval_all_i,
    input  logic          blk_we_i,
    input  logic [IW-1:0] blk_idx_i,
    input  logic [BW-1:0] blk_base_i,
    input  logic [MW-1:0] blk_mask_i,
    input  logic [BW-1:0] blk_phys_i,
    input  logic          blk_sv_i,
    input  logic          blk_uv_i,
    input  logic          blk_ro_i,
    input  logic          pg_we_i,
    input  logic [PW-1:0] pg_vpn_i,
    input  logic [PW-1:0] pg_ppn_i,
    input  logic          pg_ro_i,
    output logic [AW-1:0] pa_o,
    output logic          hit_o,
    output logic          src_blk_o,
    output logic          miss_o,
    output logic          fault_o
);
    blk_entry_t    blk_wr;
    logic          b_hit, b_ro, p_hit, p_ro;
    logic [AW-1:0] b_pa, p_pa;

    xl_blk_array #(.N(BLK_N)) i_blk (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (blk_we_i),
        .widx_i   (blk_idx_i),
        .wentry_i (blk_wr),
        .ea_i     (ea_i),
        .super_i  (super_i),
        .hit_o    (b_hit),
        .ro_o     (b_ro),
        .pa_o     (b_pa)
    );

    assign blk_wr = '{base: blk_base_i, mask: blk_mask_i, phys: blk_phys_i,
                      sv: blk_sv_i, uv: blk_uv_i, ro: blk_ro_i};

    xl_page_buf #(.SETS(PG_SETS)) i_pg (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_i   (req_i),
        .ea_i       (ea_i),
        .inval_i    (inval_all_i),
        .fill_we_i  (pg_we_i),
        .fill_vpn_i (pg_vpn_i),
        .fill_ppn_i (pg_ppn_i),
        .fill_ro_i  (pg_ro_i),
        .hit_o      (p_hit),
        .ro_o       (p_ro),
        .pa_o       (p_pa)
    );

    xl_state_e     state_q, state_d;
    logic [AW-1:0] pa_q, pa_d;
    logic          src_q, src_d;

    always_comb begin
        state_d = XS_IDLE;
        pa_d    = '0;
        src_d   = 1'b0;
        if (req_i) begin
            if (b_hit) begin
                src_d   = 1'b1;
                pa_d    = b_pa;
                state_d = (write_i && b_ro) ? XS_FAULT : XS_HIT;
            end else if (p_hit) begin
                pa_d    = p_pa;
                state_d = (write_i && p_ro) ? XS_FAULT : XS_HIT;
            end else begin
                state_d = XS_MISS;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            pa_q    <= '0;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pa_q    <= pa_d;
            src_q   <= src_d;
        end
    end

    always_comb begin
        pa_o      = '0;
        hit_o     = 1'b0;
        src_blk_o = 1'b0;
        miss_o    = 1'b0;
        fault_o   = 1'b0;
        unique case (state_q)
            XS_IDLE:  ;
            XS_HIT: begin
                hit_o     = 1'b1;
                pa_o      = pa_q;
                src_blk_o = src_q;
            end
            XS_MISS:  miss_o = 1'b1;
            XS_FAULT: begin
                fault_o   = 1'b1;
                src_blk_o = src_q;
            end
            default:  ;
        endcase
    end

    // R2
    idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !hit_o && !miss_o && !fault_o);

    // R10
    miss_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !b_hit && !p_hit) |=> miss_o && !hit_o);

    // R7
    blk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && b_hit && !(write_i && b_ro)) |=> hit_o && src_blk_o);

    // R9
    ro_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && write_i && b_hit && b_ro) |=> fault_o && !hit_o);
endmodule

// File: tb/test_addr_xlate.sv
module test_addr_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [31:0] ea_i = '0;
    logic        super_i = 1'b0;
    logic        write_i = 1'b0;
    logic        inval_all_i = 1'b0;
    logic        blk_we_i = 1'b0;
    logic [1:0]  blk_idx_i = '0;
    logic [14:0] blk_base_i = '0;
    logic [10:0] blk_mask_i = '0;
    logic [14:0] blk_phys_i = '0;
    logic        blk_sv_i = 1'b0;
    logic        blk_uv_i = 1'b0;
    logic        blk_ro_i = 1'b0;
    logic        pg_we_i = 1'b0;
    logic [19:0] pg_vpn_i = '0;
    logic [19:0] pg_ppn_i = '0;
    logic        pg_ro_i = 1'b0;
    logic [31:0] pa_o;
    logic        hit_o, src_blk_o, miss_o, fault_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic req_d = 1'b0;

    typedef struct {
        logic        hit;
        logic        src;
        logic        miss;
        logic        fault;
        logic [31:0] pa;
        string       rq;
    } exp_t;
    exp_t sb_q [$];

    always #10 clk = ~clk;

    addr_xlate i_addr_xlate (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ea_i(ea_i), .super_i(super_i),
        .write_i(write_i), .inval_all_i(inval_all_i), .blk_we_i(blk_we_i),
        .blk_idx_i(blk_idx_i), .blk_base_i(blk_base_i), .blk_mask_i(blk_mask_i),
        .blk_phys_i(blk_phys_i), .blk_sv_i(blk_sv_i), .blk_uv_i(blk_uv_i),
        .blk_ro_i(blk_ro_i), .pg_we_i(pg_we_i), .pg_vpn_i(pg_vpn_i),
        .pg_ppn_i(pg_ppn_i), .pg_ro_i(pg_ro_i), .pa_o(pa_o), .hit_o(hit_o),
        .src_blk_o(src_blk_o), .miss_o(miss_o), .fault_o(fault_o)
    );

    always @(posedge clk) req_d <= req_i;

    // monitor: result due at the falling edge after the sampling edge
    always @(negedge clk) begin
        if (req_d) begin
            exp_t e;
            if (sb_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard: result without expectation");
            end else begin
                e = sb_q.pop_front();
                n_cmp++;
                if (hit_o !== e.hit || miss_o !== e.miss || fault_o !== e.fault ||
                    (e.hit && (src_blk_o !== e.src || pa_o !== e.pa))) begin
                    n_bad++;
                    $display("FAIL %s: got hit=%b src=%b miss=%b fault=%b pa=%h, expected hit=%b src=%b miss=%b fault=%b pa=%h",
                             e.rq, hit_o, src_blk_o, miss_o, fault_o, pa_o,
                             e.hit, e.src, e.miss, e.fault, e.pa);
                end
            end
        end
    end

    task automatic lookup(input logic [31:0] ea, input logic sup, input logic wr,
                          input logic eh, input logic es, input logic em,
                          input logic ef, input logic [31:0] epa, input string rq);
        exp_t e;
        @(negedge clk);
        req_i = 1'b1; ea_i = ea; super_i = sup; write_i = wr;
        e.hit = eh; e.src = es; e.miss = em; e.fault = ef; e.pa = epa; e.rq = rq;
        sb_q.push_back(e);
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic check_idle(input string rq);
        @(negedge clk);
        n_cmp++;
        if (hit_o !== 1'b0 || miss_o !== 1'b0 || fault_o !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: got hit=%b miss=%b fault=%b, expected all 0",
                     rq, hit_o, miss_o, fault_o);
        end
    endtask

    task automatic load_blk(input logic [1:0] idx, input logic [31:0] base_ea,
                            input logic [10:0] mask, input logic [31:0] phys,
                            input logic sv, input logic uv, input logic ro);
        @(negedge clk);
        blk_we_i = 1'b1; blk_idx_i = idx; blk_base_i = base_ea[31:17];
        blk_mask_i = mask; blk_phys_i = phys[31:17];
        blk_sv_i = sv; blk_uv_i = uv; blk_ro_i = ro;
        @(negedge clk);
        blk_we_i = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn, input logic ro);
        @(negedge clk);
        pg_we_i = 1'b1; pg_vpn_i = vpn; pg_ppn_i = ppn; pg_ro_i = ro;
        @(negedge clk);
        pg_we_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        n_cmp++;
        if (hit_o !== 1'b0 || miss_o !== 1'b0 || fault_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: flags in reset hit=%b miss=%b fault=%b, expected 000",
                     hit_o, miss_o, fault_o);
        end
        rst_n = 1'b1;
        lookup(32'h1001_ABCD, 1'b1, 1'b0, 0, 0, 1, 0, '0, "R1 empty after reset");
        check_idle("R2 no request after lookup");

        // block entries
        load_blk(2'd0, 32'h1000_0000, 11'h000, 32'h2000_0000, 1, 0, 0);
        load_blk(2'd1, 32'h4000_0000, 11'h00F, 32'h0800_0000, 1, 1, 1);
        load_blk(2'd2, 32'h6000_0000, 11'h7FF, 32'h1000_0000, 1, 1, 0);
        load_blk(2'd3, 32'h6000_0000, 11'h000, 32'h0C00_0000, 1, 1, 0);

        // R3 / R13 supervisor block hit
        lookup(32'h1001_ABCD, 1, 0, 1, 1, 0, 0, 32'h2001_ABCD, "R3 supervisor block hit");
        // R5 user not valid on entry 0
        lookup(32'h1001_ABCD, 0, 0, 0, 0, 1, 0, '0, "R5 user blocked");
        // R4 128 KB bound
        lookup(32'h1002_0000, 1, 0, 0, 0, 1, 0, '0, "R4 outside 128KB block");
        // R4 mask pass-through
        lookup(32'h4015_6789, 0, 0, 1, 1, 0, 0, 32'h0815_6789, "R4 2MB masked bits");
        lookup(32'h4025_0000, 1, 0, 0, 0, 1, 0, '0, "R4 outside 2MB block");
        // R9 read-only block
        lookup(32'h4015_6789, 1, 1, 0, 0, 0, 1, '0, "R9 write to ro block");
        // R8 lowest index
        lookup(32'h6001_2345, 1, 0, 1, 1, 0, 0, 32'h1001_2345, "R8 lowest entry wins");

        // R6 pages
        refill(20'h00003, 20'hABCDE, 0);
        lookup(32'h0000_3456, 0, 1, 1, 0, 0, 0, 32'hABCD_E456, "R6 page hit");
        refill(20'h00005, 20'h11111, 1);
        lookup(32'h0000_5010, 0, 1, 0, 0, 0, 1, '0, "R9 write to ro page");
        lookup(32'h0000_5010, 0, 0, 1, 0, 0, 0, 32'h1111_1010, "R9 read of ro page");
        // R7 block beats page; R5 user falls through to page
        refill(20'h1001A, 20'h77777, 0);
        lookup(32'h1001_ABCD, 1, 0, 1, 1, 0, 0, 32'h2001_ABCD, "R7 block over page");
        lookup(32'h1001_ABCD, 0, 0, 1, 0, 0, 0, 32'h7777_7BCD, "R5 user uses page");
        refill(20'h40156, 20'h12345, 0);
        lookup(32'h4015_6789, 1, 1, 0, 0, 0, 1, '0, "R9 ro block beats rw page");
        // R10
        lookup(32'h0000_8000, 1, 0, 0, 0, 1, 0, '0, "R10 plain miss");

        // R11 hit protects a way
        refill(20'h00007, 20'hA0000, 0);
        refill(20'h00027, 20'hB0000, 0);
        lookup(32'h0000_7000, 1, 0, 1, 0, 0, 0, 32'hA000_0000, "R11 first fill present");
        refill(20'h00047, 20'hC0000, 0);
        lookup(32'h0002_7000, 1, 0, 0, 0, 1, 0, '0, "R11 victim after hit");
        lookup(32'h0000_7000, 1, 0, 1, 0, 0, 0, 32'hA000_0000, "R11 recently used kept");
        lookup(32'h0004_7000, 1, 0, 1, 0, 0, 0, 32'hC000_0000, "R11 new fill present");
        // R11 fills only
        refill(20'h00009, 20'hA2000, 0);
        refill(20'h00029, 20'hB2000, 0);
        refill(20'h00049, 20'hC2000, 0);
        lookup(32'h0000_9000, 1, 0, 0, 0, 1, 0, '0, "R11 oldest replaced");
        lookup(32'h0002_9000, 1, 0, 1, 0, 0, 0, 32'hB200_0000, "R11 second kept");

        // R12 flush
        @(negedge clk); inval_all_i = 1'b1;
        @(negedge clk); inval_all_i = 1'b0;
        lookup(32'h0000_3456, 0, 0, 0, 0, 1, 0, '0, "R12 page gone");
        lookup(32'h0004_7000, 1, 0, 0, 0, 1, 0, '0, "R12 page gone 2");
        lookup(32'h1001_ABCD, 1, 0, 1, 1, 0, 0, 32'h2001_ABCD, "R12 block kept");

        // R13 overwrite entry 0 as invalid
        load_blk(2'd0, 32'h1000_0000, 11'h000, 32'h2000_0000, 0, 0, 0);
        lookup(32'h1001_ABCD, 1, 0, 0, 0, 1, 0, '0, "R13 entry rewritten");
        check_idle("R2 idle at end");

        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: %0d results missing, expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule